// File: doc/BRIEF.md
# External Interrupt Request Latch

This block captures requests from one active-low external interrupt pin into a pending latch. The pin is synchronized to the core clock, and a falling edge on the synchronized level sets the latch. The latch drives an interrupt request to the CPU unless the mask bit is set. The CPU acknowledges the request either with a vector-fetch strobe or by writing one to a self-clearing acknowledge bit in a small control/status register. Both paths behave the same way.

There are two operating modes. In edge mode an acknowledge clears the latch at once. In edge-and-level mode the latch clears only when an acknowledge has been seen and the pin is back high. The two conditions may come in either order, and an acknowledge that arrives while the pin is low is held until the pin rises. The block also presents the fixed two-byte vector address pair and the synchronized pin level.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the register reads 0 (mode 0, mask 0, pending 0). irq_o is 0 and pin_level_o is 0.
- R2: A falling edge on pin_ni sets pending (register bit 3). The bit is visible after the third rising clock edge following the pin change, because there are two synchronizer stages and one edge-detect stage. Holding the pin low without an edge does not set it.
- R3: With mode (bit 0) at 0, a one-cycle vec_fetch_i pulse, or a register write with bit 2 set, clears pending on that clock edge, whatever the pin level.
- R4: With mode at 1, an acknowledge while the synchronized pin is low leaves pending set. Pending then clears on the first edge at which the synchronized pin is high, with no further acknowledge.
- R5: With mode at 1 and the synchronized pin already high, pending stays set until an acknowledge arrives, and clears on that acknowledge.
- R6: If a falling edge and an acknowledge land on the same clock edge, pending stays set. In mode 1 that acknowledge is also discarded, so the pin going high later does not clear it.
- R7: A falling edge after an acknowledge sets pending again.
- R8: Reset clears pending, the mode bit and any held acknowledge, even while the pin is held low. Only a new falling edge sets pending after reset.
- R9: The mask (bit 1) forces irq_o to 0 without affecting the pending bit. With the mask at 0, irq_o equals pending.
- R10: Register bit 2 always reads 0. A write updates bit 0 and bit 1 from the written data, and bit 3 ignores writes.
- R11: vec_hi_addr_o is 0xFFFA and vec_lo_addr_o is 0xFFFB.
- R12: pin_level_o follows pin_ni with a delay of two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_ni | input | 1 | External active-low interrupt pin (asynchronous) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 4 | Write data: bit0 mode, bit1 mask, bit2 acknowledge |
| reg_rdata_o | output | 4 | Read data: bit0 mode, bit1 mask, bit2 zero, bit3 pending |
| vec_fetch_i | input | 1 | Vector-fetch acknowledge strobe from the CPU |
| irq_o | output | 1 | Interrupt request to the CPU |
| pin_level_o | output | 1 | Synchronized pin level |
| vec_hi_addr_o | output | 16 | Address of the vector high byte |
| vec_lo_addr_o | output | 16 | Address of the vector low byte |

## Verification
The hardest case to reach is an acknowledge that lands on the same clock edge as a new falling edge. The detected edge trails the pin by two synchronizer stages, so the stimulus drives the pin low and then waits exactly two falling clock edges before raising the acknowledge strobe. This places both events on the third rising edge. The case is run in both modes, and in level mode the pin is then released to show that the acknowledge was discarded. A behavioural reference model with a queue of pin samples is compared with every output on every clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W    = 4;
  localparam int unsigned MODE_BIT = 0;
  localparam int unsigned MASK_BIT = 1;
  localparam int unsigned ACK_BIT  = 2;
  localparam int unsigned PEND_BIT = 3;

  typedef struct packed {
    logic mask;
    logic level_mode;
  } irq_ctrl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned CW = STAGES + 1;

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous sample.
  // Reset to 0 so a pin held low through reset gives no false edge.
  logic [CW-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[CW-2:0], pin_ni};
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_mode_i,
  input  logic fall_i,
  input  logic pin_hi_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q, ack_held_q;
  logic ack_any, clr, pend_d, ack_held_d;

  assign ack_any = ack_i | (level_mode_i & ack_held_q);
  // Edge mode: acknowledge alone. Level mode: acknowledge and pin high.
  assign clr     = level_mode_i ? (ack_any & pin_hi_i) : ack_i;
  assign pend_d  = fall_i | (pend_q & ~clr);
  // Hold an acknowledge seen while the pin is low; a new edge discards it.
  assign ack_held_d = level_mode_i & pend_q & ~fall_i & ack_any & ~pin_hi_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      ack_held_q <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      ack_held_q <= ack_held_d;
    end
  end

  assign pend_o = pend_q;

  a_r2_fall_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> pend_o);
  a_r3_edge_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_mode_i && pend_o && ack_i && !fall_i) |=> !pend_o);
  a_r4_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_mode_i && pend_o && !pin_hi_i) |=> pend_o);
  a_r6_edge_drops_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |=> !ack_held_q);
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import ext_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pend_i,
  output irq_ctrl_t        ctrl_o,
  output logic             ack_sw_o,
  output logic [REG_W-1:0] rdata_o
);
  irq_ctrl_t ctrl_q;
  logic      unused_wbit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i) begin
      ctrl_q.level_mode <= wdata_i[MODE_BIT];
      ctrl_q.mask       <= wdata_i[MASK_BIT];
    end
  end

  assign ack_sw_o    = wr_i & wdata_i[ACK_BIT];
  assign unused_wbit = wdata_i[PEND_BIT];
  assign ctrl_o      = ctrl_q;

  always_comb begin
    rdata_o           = '0;
    rdata_o[MODE_BIT] = ctrl_q.level_mode;
    rdata_o[MASK_BIT] = ctrl_q.mask;
    rdata_o[PEND_BIT] = pend_i;
  end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int unsigned      SYNC_STAGES = 2,
  parameter int unsigned      ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_ni,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              vec_fetch_i,
  output logic              irq_o,
  output logic              pin_level_o,
  output logic [ADDR_W-1:0] vec_hi_addr_o,
  output logic [ADDR_W-1:0] vec_lo_addr_o
);
  logic      pin_hi, fall, pend, ack_sw;
  irq_ctrl_t ctrl;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_ni  (pin_ni),
    .level_o (pin_hi),
    .fall_o  (fall)
  );

  irq_csr u_csr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .wdata_i  (reg_wdata_i),
    .pend_i   (pend),
    .ctrl_o   (ctrl),
    .ack_sw_o (ack_sw),
    .rdata_o  (reg_rdata_o)
  );

  irq_pend_ctrl u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .level_mode_i (ctrl.level_mode),
    .fall_i       (fall),
    .pin_hi_i     (pin_hi),
    .ack_i        (vec_fetch_i | ack_sw),
    .pend_o       (pend)
  );

  assign irq_o         = pend & ~ctrl.mask;
  assign pin_level_o   = pin_hi;
  assign vec_hi_addr_o = VEC_ADDR;
  assign vec_lo_addr_o = VEC_ADDR + ADDR_W'(1);

  a_r9_mask_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[MASK_BIT] |-> !irq_o);
  a_r9_pend_drives_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[MASK_BIT] && reg_rdata_o[PEND_BIT]) |-> irq_o);
  a_r10_ack_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[ACK_BIT]);
endmodule

// File: tb/tb_ext_irq_latch.sv
module tb_ext_irq_latch;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_wdata = '0;
  logic [3:0]  reg_rdata;
  logic        vec_fetch = 1'b0;
  logic        irq, pin_level;
  logic [15:0] vec_hi, vec_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ext_irq_latch dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_ni(pin),
    .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .vec_fetch_i(vec_fetch), .irq_o(irq), .pin_level_o(pin_level),
    .vec_hi_addr_o(vec_hi), .vec_lo_addr_o(vec_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model
  logic smp[$] = '{1'b0, 1'b0, 1'b0};
  bit m_pend = 0, m_mode = 0, m_mask = 0, m_ackseen = 0, m_level = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp = '{1'b0, 1'b0, 1'b0};
      m_pend = 0; m_mode = 0; m_mask = 0; m_ackseen = 0; m_level = 0;
    end else begin
      bit ack, fall_now, hi_now;
      ack      = vec_fetch || (reg_wr && reg_wdata[2]);
      hi_now   = smp[1];
      fall_now = smp[2] && !smp[1];
      if (m_pend) begin
        if (!m_mode) begin
          if (ack) m_pend = 0;
          m_ackseen = 0;
        end else begin
          if (ack) m_ackseen = 1;
          if (m_ackseen && hi_now) begin m_pend = 0; m_ackseen = 0; end
        end
      end
      if (fall_now) begin m_pend = 1; m_ackseen = 0; end
      if (reg_wr) begin m_mode = reg_wdata[0]; m_mask = reg_wdata[1]; end
      smp.push_front(pin);
      void'(smp.pop_back());
      m_level = smp[1];
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(reg_rdata[3], m_pend, "R2 pending vs model");
      chk(reg_rdata[1:0], {m_mask, m_mode}, "R10 ctrl bits vs model");
      chk(reg_rdata[2], 0, "R10 ack bit reads zero");
      chk(irq, m_pend && !m_mask, "R9 irq vs model");
      chk(pin_level, m_level, "R12 pin level vs model");
      chk(vec_hi, 16'hFFFA, "R11 vector high");
      chk(vec_lo, 16'hFFFB, "R11 vector low");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [3:0] d);
    reg_wr = 1'b1; reg_wdata = d; @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask
  task automatic fetch();
    vec_fetch = 1'b1; @(negedge clk); vec_fetch = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    chk(reg_rdata, 0, "R1 reset register");
    chk(irq, 0, "R1 reset irq");
    chk(pin_level, 0, "R1 reset level");
    cyc(3);
    chk(pin_level, 1, "R12 level high");
    // Edge mode
    pin = 0; cyc(4);
    chk(reg_rdata[3], 1, "R2 fall sets pending");
    chk(pin_level, 0, "R12 level low");
    fetch();
    chk(reg_rdata[3], 0, "R3 fetch clears in edge mode");
    cyc(4);
    chk(reg_rdata[3], 0, "R2 held low no retrigger");
    pin = 1; cyc(3); pin = 0; cyc(4);
    chk(reg_rdata[3], 1, "R7 fall after ack sets again");
    wr(4'h4);
    chk(reg_rdata[3], 0, "R3 software ack clears");
    // Mask
    wr(4'h2); pin = 1; cyc(3); pin = 0; cyc(4);
    chk(reg_rdata[3], 1, "R9 pending while masked");
    chk(irq, 0, "R9 masked irq low");
    wr(4'h0);
    chk(irq, 1, "R9 unmasked irq high");
    wr(4'h4);
    // Level mode, ack first
    pin = 1; cyc(3); wr(4'h1); pin = 0; cyc(4);
    chk(reg_rdata[3], 1, "R2 level mode fall sets");
    fetch(); cyc(5);
    chk(reg_rdata[3], 1, "R4 ack while low holds");
    pin = 1; cyc(4);
    chk(reg_rdata[3], 0, "R4 clears on pin high");
    // Level mode, pin first
    pin = 0; cyc(4); pin = 1; cyc(4);
    chk(reg_rdata[3], 1, "R5 pin high without ack holds");
    wr(4'h5);
    chk(reg_rdata[3], 0, "R5 ack clears with pin high");
    chk(reg_rdata[0], 1, "R10 mode kept");
    // Edge and ack coincide, edge mode
    wr(4'h0); pin = 0; cyc(4); pin = 1; cyc(4); pin = 0; cyc(2); fetch();
    chk(reg_rdata[3], 1, "R6 edge mode coincident edge wins");
    pin = 1; cyc(3); fetch();
    chk(reg_rdata[3], 0, "R3 clear after coincidence");
    // Edge and ack coincide, level mode
    wr(4'h1); pin = 0; cyc(4); pin = 1; cyc(4);
    chk(reg_rdata[3], 1, "R5 level pending kept");
    pin = 0; cyc(2); fetch(); pin = 1; cyc(4);
    chk(reg_rdata[3], 1, "R6 level coincident ack discarded");
    fetch();
    chk(reg_rdata[3], 0, "R6 later ack clears");
    // Reset with pin low and held ack
    pin = 0; cyc(4); fetch();
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
    chk(reg_rdata, 0, "R8 reset drops request with pin low");
    wr(4'h1); pin = 1; cyc(4);
    chk(reg_rdata[3], 0, "R8 no set on rise after reset");
    pin = 0; cyc(4);
    chk(reg_rdata[3], 1, "R8 new fall sets");
    pin = 1; cyc(4);
    chk(reg_rdata[3], 1, "R8 held ack was cleared");
    fetch();
    chk(reg_rdata[3], 0, "R5 clear after reset test");
    // Register readback
    wr(4'hF);
    chk(reg_rdata, 4'h3, "R10 readback after full write");
    wr(4'h0);
    chk(vec_hi, 16'hFFFA, "R11 vec hi");
    chk(vec_lo, 16'hFFFB, "R11 vec lo");
    cyc(2);
    finish_run();
  end
endmodule